// File: doc/BRIEF.md
# Write Protection Controller for a Serial Non-Volatile Memory

This block decides, for every byte a serial memory interface wants to write, whether that write may go ahead. It holds the 8-bit protection status byte and the write-enable latch. The command decoder that sits in front of it delivers one-cycle pulses for "arm writes", "disarm writes", "write instruction finished" and "status byte written". It also presents the target of the pending byte as an access kind and a 24-bit address. The block answers with a single combinational permit and shows the status byte for read-back.

Protection has three layers. The write-enable latch must be set for any write. A block-protect code with an anchor bit selects a power-of-two slice of the main array that can never be written, anchored either at the top or at the bottom of the address space. The density setting scales this slice. A hardware protect pin can freeze the status byte, but only while the status byte itself enables that pin. The pin level is captured when the chip select falls and is held for the rest of the transaction.

The block contains two small state machines. The sampler has the states SMP_IDLE (deselected) and SMP_HELD (selected, pin level frozen). It moves SMP_IDLE to SMP_HELD on the first clock with chip select low, and SMP_HELD to SMP_IDLE on the first clock with chip select high. The latch machine has the states WEL_CLEAR and WEL_ARMED. It moves WEL_CLEAR to WEL_ARMED on an arm pulse that comes with no clearing pulse. It moves WEL_ARMED to WEL_CLEAR on a disarm pulse or an end-of-write pulse.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte reads 8'h00 and the permit is 0 for every access kind.
- R2: Bit 1 of the status byte is the write-enable latch. An arm pulse sets it on the next clock and a disarm pulse clears it. When both pulses come in the same cycle, the latch ends up cleared.
- R3: An end-of-write pulse clears the latch on the next clock.
- R4: Bit 0 always reads 0. A status write loads data bits 7:2 into status bits 7:2 on the next clock and never changes bits 1:0.
- R5: With the latch at 0 the permit is 0 for every kind: array (code 0), status (1), serial number (2) and auxiliary array (3). A status write issued then leaves the status byte unchanged.
- R6: Status bits 4:2 hold the protect code c. Code 0 protects nothing. Codes 1 to 6 protect 1/2^(7-c) of the array, from 1/64 up to 1/2. Code 7 protects the whole array. A protected array address gets permit 0 even with the latch set.
- R7: With status bit 5 at 0 the protected slice lies at the highest array addresses. With it at 1 the slice starts at address 0.
- R8: The density input takes the values 0, 1, 2 and 3, which give 17, 19, 20 and 21 active address bits. Address bits above the active ones take no part in the range decision.
- R9: A status-kind write is permitted with the latch set, unless status bit 7 is 1 and the sampled protect pin is low.
- R10: The protect pin is sampled on the first clock with chip select low. Later changes of the pin during that selection have no effect.
- R11: A serial-number write is blocked when status bit 6 is 1. Otherwise it needs only the latch.
- R12: An auxiliary-array write needs only the latch and ignores the protect code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, low while a transaction runs |
| wp_n | input | 1 | Hardware protect pin, low means protect |
| density | input | 2 | Array size: 0=17, 1=19, 2=20, 3=21 address bits |
| cmd_wren | input | 1 | Arm-writes pulse |
| cmd_wrdi | input | 1 | Disarm-writes pulse |
| cmd_wr_end | input | 1 | End of a write instruction pulse |
| sr_wr_valid | input | 1 | Status write pulse |
| sr_wr_data | input | 8 | Status write data |
| chk_kind | input | 2 | Access kind: 0 array, 1 status, 2 serial, 3 aux |
| chk_addr | input | 24 | Target array address |
| status_out | output | 8 | Status byte for read-back |
| write_ok | output | 1 | Permit for the pending byte |

## Verification
The range decision is driven by a vector table. Each vector pairs an address just inside a slice boundary with one just outside it, for top and bottom anchoring and for every density. This shows whether the slice size, the anchor and the density scaling each come out right. Other vectors use codes 0 and 7 and set address bits above the active width, which separates the no-slice and whole-array cases and the masking of high bits. Directed sequences then flip the protect pin in the middle of a selection, issue simultaneous arm and disarm pulses, and write all ones to the status byte. These show the pin freeze, the clear-wins priority and the read-only low bits apart from ordinary writes.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int ADDR_W   = 24;
    localparam int CODE_W   = 3;
    localparam int FRAC_MAX = 7;

    localparam int BIT_PIN_EN  = 7;
    localparam int BIT_SN_LOCK = 6;
    localparam int BIT_ANCHOR  = 5;
    localparam int BIT_CODE_HI = 4;
    localparam int BIT_CODE_LO = 2;
    localparam int BIT_WEL     = 1;

    typedef enum logic [1:0] {
        ACC_ARRAY  = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_SERIAL = 2'd2,
        ACC_AUX    = 2'd3
    } acc_kind_e;

    typedef enum logic {
        SMP_IDLE = 1'b0,
        SMP_HELD = 1'b1
    } smp_state_e;

    typedef enum logic {
        WEL_CLEAR = 1'b0,
        WEL_ARMED = 1'b1
    } wel_state_e;

    function automatic int dens_bits(input logic [1:0] d);
        case (d)
            2'd0:    return 17;
            2'd1:    return 19;
            2'd2:    return 20;
            default: return 21;
        endcase
    endfunction

endpackage

// File: rtl/wp_sampler.sv
module wp_sampler
    import wp_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wp_n,
    output logic wp_held
);
    smp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SMP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMP_IDLE: if (!cs_n) state_d = SMP_HELD;
            SMP_HELD: if (cs_n)  state_d = SMP_IDLE;
        endcase
    end

    // pin level is captured only on the entry into SMP_HELD
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wp_held <= 1'b0;
        else if (state_q == SMP_IDLE && !cs_n)
            wp_held <= wp_n;
    end
endmodule

// File: rtl/wel_ctrl.sv
module wel_ctrl
    import wp_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic wr_end,
    output logic wel
);
    wel_state_e state_q, state_d;
    logic       clr;

    assign clr = disarm | wr_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WEL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WEL_CLEAR: if (arm && !clr) state_d = WEL_ARMED;
            WEL_ARMED: if (clr)         state_d = WEL_CLEAR;
        endcase
    end

    always_comb wel = (state_q == WEL_ARMED);
endmodule

// File: rtl/prot_range.sv
module prot_range
    import wp_guard_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W
) (
    input  logic [1:0]    density,
    input  logic          anchor_low,
    input  logic [CW-1:0] code,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int FULL = (1 << CW) - 1;

    int          nbits;
    int          lo_bit;
    logic [AW-1:0] lim_m;
    logic [AW-1:0] blk_m;
    logic [AW-1:0] sel_m;
    logic [AW-1:0] masked;

    always_comb begin
        nbits  = dens_bits(density);
        lo_bit = nbits - FULL + int'(code);
    end

    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign lim_m[i] = (i < nbits);
        assign blk_m[i] = (i >= lo_bit);
    end

    assign sel_m  = lim_m & blk_m;
    assign masked = addr & sel_m;

    always_comb begin
        if (int'(code) == 0)
            hit = 1'b0;
        else if (int'(code) == FULL)
            hit = 1'b1;
        else if (anchor_low)
            hit = (masked == '0);
        else
            hit = (masked == sel_m);
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        wp_n,
    input  logic [1:0]  density,
    input  logic        cmd_wren,
    input  logic        cmd_wrdi,
    input  logic        cmd_wr_end,
    input  logic        sr_wr_valid,
    input  logic [7:0]  sr_wr_data,
    input  logic [1:0]  chk_kind,
    input  logic [23:0] chk_addr,
    output logic [7:0]  status_out,
    output logic        write_ok
);
    localparam int CFG_W = BIT_PIN_EN - BIT_CODE_LO + 1;

    logic             wp_held;
    logic             wel;
    logic [CFG_W-1:0] cfg_q;
    logic             in_range;
    logic             sr_open;
    acc_kind_e        kind;

    wp_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wp_n    (wp_n),
        .wp_held (wp_held)
    );

    wel_ctrl u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (cmd_wren),
        .disarm (cmd_wrdi),
        .wr_end (cmd_wr_end),
        .wel    (wel)
    );

    assign status_out = {cfg_q, wel, 1'b0};

    prot_range #(.AW(ADDR_W), .CW(CODE_W)) u_rng (
        .density    (density),
        .anchor_low (status_out[BIT_ANCHOR]),
        .code       (status_out[BIT_CODE_HI:BIT_CODE_LO]),
        .addr       (chk_addr),
        .hit        (in_range)
    );

    assign sr_open = wel && !(status_out[BIT_PIN_EN] && !wp_held);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (sr_wr_valid && sr_open)
            cfg_q <= sr_wr_data[BIT_PIN_EN:BIT_CODE_LO];
    end

    assign kind = acc_kind_e'(chk_kind);

    always_comb begin
        write_ok = 1'b0;
        unique case (kind)
            ACC_ARRAY:  write_ok = wel && !in_range;
            ACC_STATUS: write_ok = sr_open;
            ACC_SERIAL: write_ok = wel && !status_out[BIT_SN_LOCK];
            ACC_AUX:    write_ok = wel;
        endcase
    end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wren,
    input logic        cmd_wrdi,
    input logic        cmd_wr_end,
    input logic        sr_wr_valid,
    input logic [1:0]  chk_kind,
    input logic [7:0]  status_out,
    input logic        write_ok
);
    // R4
    bit0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_out[0] == 1'b0);

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !cmd_wr_end) |=> status_out[1]);

    // R3
    wel_end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_end |=> !status_out[1]);

    // R5
    no_wel_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        write_ok |-> status_out[1]);

    // R5
    no_wel_sr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_valid && !status_out[1]) |=> (status_out[7:2] == $past(status_out[7:2])));

    // R11
    sn_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_kind == 2'd2 && status_out[6]) |-> !write_ok);

    // R6
    full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_kind == 2'd0 && status_out[4:2] == 3'd7) |-> !write_ok);
endmodule

bind wp_guard wp_guard_chk u_chk (.*);

// File: tb/sim_wp_guard.sv
`timescale 1ns/1ps
module sim_wp_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wp_n = 1'b1;
    logic [1:0]  density = 2'd0;
    logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wr_end = 1'b0;
    logic        sr_wr_valid = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic [1:0]  chk_kind = 2'd0;
    logic [23:0] chk_addr = 24'h0;
    logic [7:0]  status_out;
    logic        write_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    wp_guard u0 (.*);

    // {density, anchor, code, addr, expected permit}
    localparam int NV = 22;
    localparam logic [30:0] VEC [NV] = '{
        {2'd0, 1'b0, 3'd0, 24'h01FFFF, 1'b1},
        {2'd0, 1'b0, 3'd1, 24'h01F800, 1'b0},
        {2'd0, 1'b0, 3'd1, 24'h01F7FF, 1'b1},
        {2'd1, 1'b0, 3'd2, 24'h07C000, 1'b0},
        {2'd1, 1'b0, 3'd2, 24'h07BFFF, 1'b1},
        {2'd2, 1'b0, 3'd6, 24'h080000, 1'b0},
        {2'd2, 1'b0, 3'd6, 24'h07FFFF, 1'b1},
        {2'd3, 1'b0, 3'd3, 24'h1E0000, 1'b0},
        {2'd3, 1'b0, 3'd3, 24'h1DFFFF, 1'b1},
        {2'd1, 1'b1, 3'd1, 24'h001FFF, 1'b0},
        {2'd1, 1'b1, 3'd1, 24'h002000, 1'b1},
        {2'd0, 1'b1, 3'd4, 24'h003FFF, 1'b0},
        {2'd0, 1'b1, 3'd4, 24'h004000, 1'b1},
        {2'd3, 1'b1, 3'd5, 24'h07FFFF, 1'b0},
        {2'd3, 1'b1, 3'd5, 24'h080000, 1'b1},
        {2'd2, 1'b1, 3'd7, 24'h0FFFFF, 1'b0},
        {2'd0, 1'b0, 3'd7, 24'h000000, 1'b0},
        {2'd2, 1'b0, 3'd5, 24'h0C0000, 1'b0},
        {2'd2, 1'b0, 3'd5, 24'h0BFFFF, 1'b1},
        {2'd0, 1'b0, 3'd1, 24'h1E0000, 1'b1},
        {2'd0, 1'b0, 3'd1, 24'h03F800, 1'b0},
        {2'd3, 1'b1, 3'd0, 24'h000000, 1'b1}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pulse_wren();
        @(negedge clk) cmd_wren = 1'b1;
        @(negedge clk) cmd_wren = 1'b0;
    endtask
    task automatic pulse_end();
        @(negedge clk) cmd_wr_end = 1'b1;
        @(negedge clk) cmd_wr_end = 1'b0;
    endtask
    task automatic write_sr(input logic [7:0] v);
        @(negedge clk) begin sr_wr_valid = 1'b1; sr_wr_data = v; end
        @(negedge clk) sr_wr_valid = 1'b0;
    endtask
    task automatic load_status(input logic [7:0] v);
        pulse_wren();
        write_sr(v);
        pulse_end();
    endtask
    task automatic probe(input logic [1:0] k, input logic [23:0] a);
        @(negedge clk) begin chk_kind = k; chk_addr = a; end
        #1;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk) #1;
        // R1 reset state
        chk(status_out, 8'h00, "R1 status after reset");
        for (int k = 0; k < 4; k++) begin
            probe(k[1:0], 24'h000000);
            chk({7'd0, write_ok}, 8'd0, "R1 permit after reset");
        end

        cs_n = 1'b0;
        @(negedge clk);

        // R6 R7 R8 range table
        for (int v = 0; v < NV; v++) begin
            density = VEC[v][30:29];
            load_status({2'b00, VEC[v][28], VEC[v][27:25], 2'b00});
            pulse_wren();
            probe(2'd0, VEC[v][24:1]);
            chk({7'd0, write_ok}, {7'd0, VEC[v][0]}, $sformatf("R6 R7 R8 vector %0d", v));
            pulse_end();
        end
        load_status(8'h00);

        // R2 arm / disarm / clear wins
        pulse_wren(); #1;
        chk(status_out, 8'h02, "R2 arm sets latch");
        @(negedge clk) cmd_wrdi = 1'b1;
        @(negedge clk) cmd_wrdi = 1'b0; #1;
        chk(status_out, 8'h00, "R2 disarm clears latch");
        @(negedge clk) begin cmd_wren = 1'b1; cmd_wrdi = 1'b1; end
        @(negedge clk) begin cmd_wren = 1'b0; cmd_wrdi = 1'b0; end #1;
        chk(status_out, 8'h00, "R2 simultaneous clear wins");

        // R3 end of write clears latch
        pulse_wren();
        pulse_end(); #1;
        chk(status_out, 8'h00, "R3 end clears latch");

        // R5 no latch: nothing permitted, status write ignored
        for (int k = 0; k < 4; k++) begin
            probe(k[1:0], 24'h000010);
            chk({7'd0, write_ok}, 8'd0, "R5 no latch no permit");
        end
        write_sr(8'h7C); #1;
        chk(status_out, 8'h00, "R5 status write without latch");

        // R4 low bits untouched
        pulse_wren();
        write_sr(8'hFF); #1;
        chk(status_out, 8'hFE, "R4 all ones write");
        pulse_end(); #1;
        chk(status_out, 8'hFC, "R4 bit1 follows latch only");
        load_status(8'h80); #1;
        chk(status_out, 8'h80, "R4 pin enable loaded");

        // R9 R10 pin gating
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) wp_n = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        pulse_wren();
        probe(2'd1, 24'h0);
        chk({7'd0, write_ok}, 8'd0, "R9 pin low blocks status");
        write_sr(8'h84); #1;
        chk(status_out, 8'h82, "R9 blocked status write");
        @(negedge clk) wp_n = 1'b1;
        probe(2'd1, 24'h0);
        chk({7'd0, write_ok}, 8'd0, "R10 pin change mid selection ignored");
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        probe(2'd1, 24'h0);
        chk({7'd0, write_ok}, 8'd1, "R10 reselect samples high pin");
        write_sr(8'h00);
        pulse_end();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) wp_n = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        pulse_wren();
        probe(2'd1, 24'h0);
        chk({7'd0, write_ok}, 8'd1, "R9 pin low but enable clear");
        pulse_end();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) wp_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;

        // R11 serial lock
        load_status(8'h40);
        pulse_wren();
        probe(2'd2, 24'h0);
        chk({7'd0, write_ok}, 8'd0, "R11 locked serial");
        write_sr(8'h00);
        probe(2'd2, 24'h0);
        chk({7'd0, write_ok}, 8'd1, "R11 unlocked serial");

        // R12 aux ignores code
        write_sr(8'h1C);
        probe(2'd3, 24'h0);
        chk({7'd0, write_ok}, 8'd1, "R12 aux with full code");
        probe(2'd0, 24'h000123);
        chk({7'd0, write_ok}, 8'd0, "R6 array with full code");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule